// File: doc/BRIEF.md
# Scan Chain of Control-Point Cells

This block is a serial chain of test-only flip-flops. Each flip-flop drives one extra two-input gate that sits on an internal net of the host logic. During test, patterns are shifted into the chain. Each stored bit then forces or releases its target net. An AND-style cell is placed on a net that is seldom 0, so that the net reaches 0 more often. An OR-style cell is placed on a net that is seldom 1, so that the net reaches 1 more often. When the stored bits are fair coin flips, a rarely toggling net toggles far more often. This makes hard-to-reach conditions much easier to excite during test.

Outside test the chain holds its contents. Each gate receives the level that cannot control it: 1 for an AND gate and 0 for an OR gate. Each net therefore passes through unchanged and mission behaviour is exactly as before insertion. The number of cells and the kind of each cell are parameters. The bit at index i of a vector parameter selects the kind for cell i.

Top module: `cp_scan_chain`

## Requirements
- R1: A synchronous active-high reset clears every chain flip-flop to 0. Directly after reset with test enable high, AND-style outputs read 0, OR-style outputs equal their inputs, and scan out reads 0.
- R2: While test enable is high, each clock edge moves the chain by one position. Position 0 loads scan in, and position i loads position i-1. Scan out is position N_CELLS-1, so a bit appears there after N_CELLS edges.
- R3: While test enable is low, the chain keeps its contents on every clock edge, whatever scan in does.
- R4: While test enable is low, every modified net equals its original net, for any input values.
- R5: With test enable high, an AND-style cell's output is its net input ANDed with the bit held in that cell's position.
- R6: With test enable high, an OR-style cell's output is its net input ORed with the bit held in that cell's position.
- R7: Bit i of parameter CELL_IS_AND selects the kind of cell i: 1 means AND-style and 0 means OR-style. Cell i uses chain position i, where position 0 is nearest scan in.
- R8: The gate path is combinational. A change of test enable or of a net input shows at the outputs in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| test_en | input | 1 | High: chain shifts and cells control their nets; low: chain holds and nets pass through |
| scan_in | input | 1 | Serial data into chain position 0 |
| net_in | input | N_CELLS | Original internal nets, one per cell |
| net_out | output | N_CELLS | Nets after the control gates |
| scan_out | output | 1 | Serial data from the last chain position |

## Verification
The bench uses a mixed map of AND-style and OR-style cells and an all-ones fill. These expose a design that swaps the two kinds or reads the kind vector in reverse; such a design would force the wrong outputs. Long mission-mode stretches with a toggling scan in are followed by a return to test mode. A chain that kept shifting outside test would show up because the restored pattern no longer matches. Test enable is also raised in the middle of a cycle with no clock edge. A registered gate path would lag one cycle behind, and a wrong idle level would corrupt the nets during mission mode.

// File: rtl/cp_chain_pkg.sv
package cp_chain_pkg;

    typedef enum logic {
        CELL_OR  = 1'b0,
        CELL_AND = 1'b1
    } cell_kind_e;

    typedef struct packed {
        logic shift_en;
        logic serial_in;
    } shift_ctl_t;

    function automatic cell_kind_e kind_of(input logic sel_bit);
        return sel_bit ? CELL_AND : CELL_OR;
    endfunction

    function automatic logic idle_level(input cell_kind_e kind);
        return (kind == CELL_AND);
    endfunction

endpackage

// File: rtl/cp_shift_stage.sv
module cp_shift_stage
    import cp_chain_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  shift_ctl_t ctl,
    output logic       state_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= 1'b0;
        end else if (ctl.shift_en) begin
            state_q <= ctl.serial_in;
        end
    end

endmodule

// File: rtl/cp_ctrl_gate.sv
module cp_ctrl_gate
    import cp_chain_pkg::*;
#(
    parameter cell_kind_e KIND = CELL_OR
) (
    input  logic test_en,
    input  logic state_bit,
    input  logic net_i,
    output logic net_o
);

    logic ctl_level;

    always_comb begin
        ctl_level = test_en ? state_bit : idle_level(KIND);
    end

    generate
        if (KIND == CELL_AND) begin : g_and
            always_comb net_o = net_i & ctl_level;
        end else begin : g_or
            always_comb net_o = net_i | ctl_level;
        end
    endgenerate

endmodule

// File: rtl/cp_scan_chain.sv
module cp_scan_chain
    import cp_chain_pkg::*;
#(
    parameter int unsigned          N_CELLS     = 8,
    parameter logic [N_CELLS-1:0]   CELL_IS_AND = N_CELLS'(8'hA6)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               test_en,
    input  logic               scan_in,
    input  logic [N_CELLS-1:0] net_in,
    output logic [N_CELLS-1:0] net_out,
    output logic               scan_out
);

    localparam int unsigned LAST = N_CELLS - 1;

    logic [N_CELLS-1:0] chain_q;

    genvar gi;
    generate
        for (gi = 0; gi < N_CELLS; gi++) begin : g_cell
            shift_ctl_t stage_ctl;

            if (gi == 0) begin : g_head
                always_comb begin
                    stage_ctl.shift_en  = test_en;
                    stage_ctl.serial_in = scan_in;
                end
            end else begin : g_body
                always_comb begin
                    stage_ctl.shift_en  = test_en;
                    stage_ctl.serial_in = chain_q[gi-1];
                end
            end

            cp_shift_stage u_stage (
                .clk     (clk),
                .rst     (rst),
                .ctl     (stage_ctl),
                .state_q (chain_q[gi])
            );

            cp_ctrl_gate #(
                .KIND (kind_of(CELL_IS_AND[gi]))
            ) u_gate (
                .test_en   (test_en),
                .state_bit (chain_q[gi]),
                .net_i     (net_in[gi]),
                .net_o     (net_out[gi])
            );

            if (CELL_IS_AND[gi]) begin : g_chk_and
                // R5
                and_force_chk: assert property (@(posedge clk) disable iff (rst)
                    (test_en && !chain_q[gi]) |-> !net_out[gi]);
            end else begin : g_chk_or
                // R6
                or_force_chk: assert property (@(posedge clk) disable iff (rst)
                    (test_en && chain_q[gi]) |-> net_out[gi]);
            end
        end
    endgenerate

    assign scan_out = chain_q[LAST];

    // R4
    transparent_chk: assert property (@(posedge clk) disable iff (rst)
        !test_en |-> (net_out == net_in));

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !test_en |=> $stable(chain_q));

    generate
        if (N_CELLS > 1) begin : g_shift_chk
            // R2
            shift_out_chk: assert property (@(posedge clk) disable iff (rst)
                test_en |=> (scan_out == $past(chain_q[LAST-1])));
        end else begin : g_shift_chk1
            // R2
            shift_out_chk: assert property (@(posedge clk) disable iff (rst)
                test_en |=> (scan_out == $past(scan_in)));
        end
    endgenerate

endmodule

// File: tb/sim_cp_scan_chain.sv
`timescale 1ns/1ps
module sim_cp_scan_chain;

    localparam int N = 8;
    localparam logic [N-1:0] CFG = 8'hA6;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         test_en = 1'b0;
    logic         scan_in = 1'b0;
    logic [N-1:0] net_in = '0;
    logic [N-1:0] net_out;
    logic         scan_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic exp_q[$];

    always #10 clk = ~clk;

    cp_scan_chain #(.N_CELLS(N), .CELL_IS_AND(CFG)) u0 (
        .clk(clk), .rst(rst), .test_en(test_en), .scan_in(scan_in),
        .net_in(net_in), .net_out(net_out), .scan_out(scan_out)
    );

    task automatic chk(input bit ok, input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // chain position i holds exp_q[N-1-i]
    function automatic logic [N-1:0] model_nets(input logic [N-1:0] ni, input logic te);
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) begin
            logic b;
            b = exp_q[N-1-i];
            if (!te)        r[i] = ni[i];
            else if (CFG[i]) r[i] = ni[i] & b;
            else             r[i] = ni[i] | b;
        end
        return r;
    endfunction

    task automatic cmp_nets(input string ctx);
        logic [N-1:0] e;
        e = model_nets(net_in, test_en);
        chk((net_out & CFG) == (e & CFG), {"R5 and-cells ", ctx}, net_out & CFG, e & CFG);
        chk((net_out & ~CFG) == (e & ~CFG), {"R6 or-cells ", ctx}, net_out & ~CFG, e & ~CFG);
    endtask

    // monitor: retire one bit per shift and compare
    always @(posedge clk) begin
        if (!rst && test_en) begin
            #5;
            void'(exp_q.pop_front());
            chk(scan_out == exp_q[0], "R2 scan_out", {7'b0, scan_out}, {7'b0, exp_q[0]});
            cmp_nets("after shift");
        end
    end

    task automatic drive_shift(input logic b, input logic [N-1:0] ni);
        @(negedge clk);
        test_en = 1'b1;
        scan_in = b;
        net_in  = ni;
        exp_q.push_back(b);
        @(posedge clk);
    endtask

    task automatic func_cycle(input logic si, input logic [N-1:0] ni);
        @(negedge clk);
        test_en = 1'b0;
        scan_in = si;
        net_in  = ni;
        #1;
        chk(net_out == ni, "R4 pass-through", net_out, ni);
        @(posedge clk);
    endtask

    initial begin
        logic [7:0] pat;
        exp_q.delete();
        for (int i = 0; i < N; i++) exp_q.push_back(1'b0);
        rst = 1'b1;
        test_en = 1'b1;
        scan_in = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        test_en = 1'b0;
        net_in = 8'hFF;
        #1;
        chk(net_out == 8'hFF, "R4 idle after reset", net_out, 8'hFF);
        test_en = 1'b1;
        #1;
        // R1: AND cells read 0, OR cells pass 1 -> ~CFG; R8 same cycle
        chk(net_out == ~CFG, "R1 reset contents / R8 comb", net_out, ~CFG);
        chk(scan_out == 1'b0, "R1 scan_out", {7'b0, scan_out}, 8'h00);
        net_in = 8'h00;
        #1;
        chk(net_out == 8'h00, "R1 zero nets", net_out, 8'h00);
        test_en = 1'b0;

        // all ones fill: R7 map check
        for (int i = 0; i < N; i++) drive_shift(1'b1, $urandom);
        @(negedge clk);
        test_en = 1'b1; net_in = 8'h00; scan_in = 1'b0;
        #1;
        chk(net_out == ~CFG, "R7 kind map, ones fill", net_out, ~CFG);
        net_in = 8'hFF;
        #1;
        chk(net_out == 8'hFF, "R7 ones fill passes", net_out, 8'hFF);
        exp_q.push_back(1'b0);
        @(posedge clk);

        // walking / patterned shifts
        pat = 8'b1011_0010;
        for (int i = 0; i < 3 * N; i++) drive_shift(pat[i % 8], $urandom);
        for (int i = 0; i < 2 * N; i++) drive_shift(1'($urandom), $urandom);

        // functional stretch: R3 hold, R4 transparency
        for (int i = 0; i < 40; i++) func_cycle(1'($urandom), $urandom);
        @(negedge clk);
        net_in = $urandom;
        test_en = 1'b1;
        #1;
        cmp_nets("R3 held contents / R8");
        scan_in = 1'b1;
        exp_q.push_back(1'b1);
        @(posedge clk);
        for (int i = 0; i < N; i++) drive_shift(1'b0, $urandom);
        for (int i = 0; i < 10; i++) func_cycle(1'b1, 8'h00);
        for (int i = 0; i < 10; i++) func_cycle(1'b0, 8'hFF);
        for (int i = 0; i < N + 2; i++) drive_shift(1'($urandom), 8'hFF);
        for (int i = 0; i < N + 2; i++) drive_shift(1'($urandom), 8'h00);

        @(negedge clk);
        test_en = 1'b0;
        repeat (2) @(posedge clk);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(20 * 50000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule